// File: doc/BRIEF.md
# Response Ones and Transition Counter

This block compresses the response of a circuit under test into one count over a self-test session. Several response lanes are first folded by an XOR tree into one monitored bit, which is the parity of the lanes. A mode input then chooses what is tallied on each valid sample: ones, zeros, rising edges, falling edges, or edges of either kind.

Edges are found by a synchronous one-shot. It compares each valid sample with the previous valid sample of the same session and produces a single-cycle enable for the counter. The counter always runs on the system clock, so a glitch on the response cannot add a count. A session lasts as long as `start_i` is high. The cycle in which `start_i` rises clears the state and also counts as the first sample cycle. The cycle after `start_i` falls raises `done_o`, and the host reads the count at that point and compares it with a golden value outside this block. The count alone does not prove the counter's top bit works. A flag output therefore reports whether that bit was set at any point in the session.

Top module: `resp_tally`

## Requirements
- R1: The monitored bit is the XOR of every bit of `resp_i`. With one valid sample in ones mode, the final count equals that parity.
- R2: In mode code 0 the counter adds one for each valid sample whose monitored bit is 1. In mode code 1 it adds one for each valid sample whose monitored bit is 0.
- R3: Mode code 2 counts 0-to-1 changes between consecutive valid samples. Mode code 3 counts 1-to-0 changes. Mode code 4 counts both kinds. Codes 5 to 7 count nothing.
- R4: The first valid sample of a session is never counted as a transition. It only becomes the reference for the next valid sample.
- R5: The count changes by at most one per clock. It changes only on a cycle where both `start_i` and `resp_valid_i` are high. Samples with `resp_valid_i` low are skipped and do not become the edge reference. While `start_i` is low, the count holds whatever appears on `resp_i`.
- R6: The count saturates at 2^CNT_W-1 and does not wrap.
- R7: `msb_seen_o` goes high once the count's most significant bit has been 1 during the session. It stays high until the next session begins. A final count of 2^(CNT_W-1)-1 leaves it low, and a final count of 2^(CNT_W-1) sets it.
- R8: A session begins on the first clock edge with `start_i` high after it was low. That edge clears the count, the flag and `done_o`. `done_o` is set by the first clock edge that samples `start_i` low after a session. It holds until the next session begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session active level; a rise begins a session |
| mode_i | input | 3 | Tally mode: 0 ones, 1 zeros, 2 rising, 3 falling, 4 both, others none |
| resp_valid_i | input | 1 | Response sample present this cycle |
| resp_i | input | LANES | Response lanes fed to the XOR concentrator |
| count_o | output | CNT_W | Session tally |
| msb_seen_o | output | 1 | Count MSB was set during the session |
| done_o | output | 1 | Session finished; count is final |

## Verification
On every cycle, the assertions check the following:
- The counter steps by at most one.
- The counter holds at its ceiling.
- The counter stays frozen while `start_i` is low.
- The MSB flag never drops within a session.
- `done_o` follows a stop and is cleared at a begin.
- In rising mode, two edges are never reported back to back.

Only the bench's scenarios can show that the final count matches the chosen mode over a whole stream of samples. The same applies to the parity produced by the concentrator, to invalid samples being skipped as edge references, and to the exact count at which the flag first rises.

// File: rtl/resp_tally_pkg.sv
package resp_tally_pkg;

    typedef enum logic [2:0] {
        TALLY_ONES  = 3'd0,
        TALLY_ZEROS = 3'd1,
        TALLY_RISE  = 3'd2,
        TALLY_FALL  = 3'd3,
        TALLY_BOTH  = 3'd4
    } tally_mode_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/resp_tally_fold.sv
module resp_tally_fold #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lanes_i,
    output logic             bit_o
);

    generate
        if (LANES == 1) begin : g_single
            assign bit_o = lanes_i[0];
        end else begin : g_tree
            logic [LANES-1:0] chain;
            assign chain[0] = lanes_i[0];
            for (genvar i = 1; i < LANES; i++) begin : g_stage
                assign chain[i] = chain[i-1] ^ lanes_i[i];
            end
            assign bit_o = chain[LANES-1];
        end
    endgenerate

endmodule

// File: rtl/resp_tally_edge.sv
module resp_tally_edge
    import resp_tally_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              valid_i,
    input  logic              bit_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              hit_o
);

    typedef struct packed {
        logic prev;
        logic have;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     have_eff;
    logic     rise, fall, sel;

    always_comb begin
        st_d     = st_q;
        have_eff = clear_i ? 1'b0 : st_q.have;
        if (clear_i) begin
            st_d.have = 1'b0;
        end
        if (valid_i) begin
            st_d.prev = bit_i;
            st_d.have = 1'b1;
        end
        rise = have_eff & ~st_q.prev &  bit_i;
        fall = have_eff &  st_q.prev & ~bit_i;
        case (mode_i)
            TALLY_ONES:  sel = bit_i;
            TALLY_ZEROS: sel = ~bit_i;
            TALLY_RISE:  sel = rise;
            TALLY_FALL:  sel = fall;
            TALLY_BOTH:  sel = rise | fall;
            default:     sel = 1'b0;
        endcase
        hit_o = valid_i & sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a one-shot cannot report two rising edges on consecutive valid samples
    a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == TALLY_RISE) |=>
            !(hit_o && valid_i && !clear_i && mode_i == TALLY_RISE));

endmodule

// File: rtl/resp_tally_count.sv
module resp_tally_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             seen_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } cnt_st_t;

    cnt_st_t st_d, st_q, base;

    always_comb begin
        base = clear_i ? '0 : st_q;
        st_d = base;
        if (en_i && base.cnt != CNT_MAX) begin
            st_d.cnt = base.cnt + 1'b1;
        end
        st_d.seen = base.seen | st_d.cnt[CNT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign seen_o = st_q.seen;

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clear_i) |=> cnt_o == CNT_MAX);

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_o && !clear_i) |=> seen_o);

endmodule

// File: rtl/resp_tally.sv
module resp_tally
    import resp_tally_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              resp_valid_i,
    input  logic [LANES-1:0]  resp_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              msb_seen_o,
    output logic              done_o
);

    typedef struct packed {
        logic active;
        logic done;
    } ses_st_t;

    ses_st_t ses_d, ses_q;
    logic    begin_s, sample_ok, mon_bit, hit;

    always_comb begin
        begin_s    = start_i & ~ses_q.active;
        sample_ok  = start_i & resp_valid_i;
        ses_d      = ses_q;
        ses_d.active = start_i;
        if (begin_s) begin
            ses_d.done = 1'b0;
        end else if (ses_q.active && !start_i) begin
            ses_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ses_q <= '0;
        end else begin
            ses_q <= ses_d;
        end
    end

    assign done_o = ses_q.done;

    resp_tally_fold #(.LANES(LANES)) fold_i (
        .lanes_i (resp_i),
        .bit_o   (mon_bit)
    );

    resp_tally_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (begin_s),
        .valid_i (sample_ok),
        .bit_i   (mon_bit),
        .mode_i  (mode_i),
        .hit_o   (hit)
    );

    resp_tally_count #(.CNT_W(CNT_W)) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (begin_s),
        .en_i    (hit),
        .cnt_o   (count_o),
        .seen_o  (msb_seen_o)
    );

    a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ses_q.active && !start_i) |=> done_o);

    a_r8_begin_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ses_q.active) |=> (!done_o && count_o <= 1));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(count_o));

endmodule

// File: tb/resp_tally_tb_top.sv
module resp_tally_tb_top;

    localparam int LANES = 4;
    localparam int CNT_W = 5;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int HALF  = 1 << (CNT_W - 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       mode_i = 3'd0;
    logic             resp_valid_i = 1'b0;
    logic [LANES-1:0] resp_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             msb_seen_o;
    logic             done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    resp_tally #(.LANES(LANES), .CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .resp_valid_i (resp_valid_i),
        .resp_i       (resp_i),
        .count_o      (count_o),
        .msb_seen_o   (msb_seen_o),
        .done_o       (done_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // rmode: 0 pseudo-random, 1 all parity one, 2 all parity zero,
    //        3 first zero then ones; vmode: 1 always valid, 0 pseudo-random
    task automatic run_session(input int mode, input int n, input int vmode,
                               input int rmode, output int exp, output int flag);
        int  havep = 0;
        bit  prev = 1'b0;
        exp  = 0;
        flag = 0;
        for (int i = 0; i < n; i++) begin
            logic [LANES-1:0] d;
            bit v, b;
            int inc;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (rmode)
                0: d = lf[LANES-1:0];
                1: d = 4'b1110;
                2: d = 4'b0110;
                default: d = (i == 0) ? 4'b0000 : 4'b1011;
            endcase
            v = (vmode != 0) ? 1'b1 : (lf[7] | lf[9]);
            start_i      = 1'b1;
            mode_i       = mode[2:0];
            resp_i       = d;
            resp_valid_i = v;
            if (v) begin
                b = ^d;
                inc = 0;
                case (mode)
                    0: inc = b ? 1 : 0;
                    1: inc = b ? 0 : 1;
                    2: inc = (havep != 0 && !prev && b) ? 1 : 0;
                    3: inc = (havep != 0 && prev && !b) ? 1 : 0;
                    4: inc = (havep != 0 && prev != b) ? 1 : 0;
                    default: inc = 0;
                endcase
                exp = (exp + inc > CMAX) ? CMAX : exp + inc;
                if (exp >= HALF) flag = 1;
                prev  = b;
                havep = 1;
            end
            @(negedge clk);
        end
        start_i      = 1'b0;
        resp_valid_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int exp, flag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset count", count_o, 0);
        check("R8 reset done", done_o, 0);
        check("R7 reset flag", msb_seen_o, 0);

        // R1: concentrator parity, every lane value
        for (int v = 0; v < 16; v++) begin
            start_i = 1'b1; mode_i = 3'd0; resp_valid_i = 1'b1; resp_i = v[3:0];
            @(negedge clk);
            start_i = 1'b0; resp_valid_i = 1'b0;
            @(negedge clk);
            check("R1 parity count", count_o, ^v[3:0]);
        end

        // R2 R3: every mode code under several stimulus patterns
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 3; p++) begin
                run_session(m, (p == 2) ? 30 : 20, (p == 0) ? 1 : 0, 0, exp, flag);
                check((m < 2) ? "R2 level count" : "R3 edge count", count_o, exp);
                check("R7 flag", msb_seen_o, flag);
                check("R8 done", done_o, 1);
            end
        end

        // R4: first sample is never a transition
        run_session(2, 1, 1, 1, exp, flag);
        check("R4 single sample rise", count_o, 0);
        run_session(4, 1, 1, 2, exp, flag);
        check("R4 single sample both", count_o, 0);
        run_session(2, 2, 1, 3, exp, flag);
        check("R4 zero then one", count_o, 1);
        run_session(2, 5, 1, 1, exp, flag);
        check("R4 steady ones", count_o, 0);

        // R6: saturation
        run_session(0, 40, 1, 1, exp, flag);
        check("R6 saturate", count_o, CMAX);
        check("R7 flag at max", msb_seen_o, 1);

        // R5: idle samples ignored, done held
        for (int i = 0; i < 10; i++) begin
            resp_valid_i = 1'b1; resp_i = i[3:0];
            @(negedge clk);
        end
        resp_valid_i = 1'b0;
        check("R5 idle hold", count_o, CMAX);
        check("R8 done held", done_o, 1);

        // R7 boundary
        run_session(0, HALF - 1, 1, 1, exp, flag);
        check("R7 count below half", count_o, HALF - 1);
        check("R7 flag below half", msb_seen_o, 0);
        run_session(0, HALF, 1, 1, exp, flag);
        check("R7 count at half", count_o, HALF);
        check("R7 flag at half", msb_seen_o, 1);

        // R8: begin clears done and count
        start_i = 1'b1; mode_i = 3'd1; resp_valid_i = 1'b0;
        @(negedge clk);
        check("R8 begin clears done", done_o, 0);
        check("R8 begin clears count", count_o, 0);
        check("R7 begin clears flag", msb_seen_o, 0);
        start_i = 1'b0;
        @(negedge clk);
        check("R8 empty session done", done_o, 1);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule